// File: doc/BRIEF.md
# NAND Flash Host Bus Sequencer

This block converts single-byte requests from a synchronous on-chip port into pin-level bus cycles for an asynchronous parallel NAND flash device. The flash is split into two regions, and each region has its own chip enable and its own ready/busy line. Each request names a cycle type (command, address, write data or read data), a target region and a byte. The sequencer then plays out one strobe cycle. It raises the command or address latch line one clock ahead of the falling strobe, holds the write or read strobe low and then high for fixed clock counts, and drives the 8-bit bus only when the host owns it.

Between bus cycles both chip enables are released, so the bus is free while a region is busy with a long program or erase. The ready/busy inputs pass through a two-flop synchronizer. After every command cycle the target region is blanked for four clocks, because the device may not yet show busy. A request to a blanked or busy region is held off, and a request to the other region can still proceed. A command request flagged as program or erase is refused while the write-protect input is low. The refusal produces a one-clock error pulse and no bus activity.

Top module: `nand_bus_seq`

## Requirements
- R1: After reset both chip enables are high, the command and address latch lines are low, both strobes are high, the bus is not driven and `req_ready` is high when both ready/busy inputs are high.
- R2: A command request (`req_kind` = 0) produces one write-strobe low pulse. Through that pulse `cle` is high, `ale` is low and `io_out` carries the request byte.
- R3: An address request (`req_kind` = 1) produces one write-strobe low pulse. Through that pulse `ale` is high and `cle` is low. A write-data request (`req_kind` = 2) strobes with both latch lines low.
- R4: `cle` and `ale` take their cycle values one clock before the strobe falls. They are never high together.
- R5: The strobe stays low for `STROBE_LO` clocks. The selected chip enable then stays low for `STROBE_HI` further clocks, plus the one setup clock before the fall.
- R6: `io_oe` is high through command, address and write-data cycles. It is low through read cycles and when idle. `we_n` and `re_n` are never low together.
- R7: A read request (`req_kind` = 3) pulses `re_n` low instead of `we_n`. The `io_in` value present in the last low clock is returned on `rd_byte`, together with a `rd_valid` pulse that lasts one clock.
- R8: During a cycle, only the chip enable of the selected region (`req_region` 0 = lower, 1 = upper) is low. Both are high between cycles.
- R9: A command request with `req_guard` high while `wp_n` is low is accepted, produces no strobe and no chip enable, and raises `err` for exactly one clock.
- R10: While the synchronized ready/busy line of a region is low, `req_ready` is low for requests to that region. Requests to the other region are unaffected.
- R11: After a command cycle completes, `req_ready` stays low for requests to that region for four clocks.
- R12: Only one bus cycle is outstanding at a time: `req_ready` is low from acceptance until the cycle's strobe-high phase ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this clock when valid |
| req_kind | input | 2 | 0 command, 1 address, 2 write data, 3 read data |
| req_region | input | 1 | Target region, 0 lower, 1 upper |
| req_guard | input | 1 | Command starts a program or erase |
| req_byte | input | 8 | Byte to send |
| rd_valid | output | 1 | One-clock pulse with returned read byte |
| rd_byte | output | 8 | Byte captured from the flash |
| err | output | 1 | One-clock pulse on a write-protect refusal |
| wp_n | input | 1 | Write protect, low blocks program and erase |
| ce_n | output | 2 | Chip enables, one per region, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| io_out | output | 8 | Bus value when driven by the host |
| io_oe | output | 1 | Host drives the bus |
| io_in | input | 8 | Bus value from the flash |
| rb_n | input | 2 | Ready/busy per region, low means busy |

## Verification
A vector table runs all four cycle types against both regions, with distinct bytes. This separates the latch-line choice, strobe choice, bus direction and chip-enable selection of each kind. Guarded commands are tried with write protect both high and low, so a refusal can be told apart from a normal guarded command. Directed tests hold one region busy while the other is probed. They also time the blanking window after a command clock by clock, which shows whether the stall is tied to the correct region and lasts the correct length.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam int NREG      = 2;
  localparam int BLANK_CYC = 4;

  typedef enum logic [1:0] {K_CMD = 2'd0, K_ADDR = 2'd1, K_WR = 2'd2, K_RD = 2'd3} kind_e;
  typedef enum logic [1:0] {P_IDLE, P_SETUP, P_LOW, P_HIGH} phase_e;

  // a guarded command cannot start while protection is active
  function automatic logic is_refused(kind_e k, logic guard, logic wp_n);
    return (k == K_CMD) && guard && !wp_n;
  endfunction

  // host owns the bus for every kind but read
  function automatic logic host_drives(kind_e k);
    return k != K_RD;
  endfunction
endpackage

// File: rtl/nand_rb_tracker.sv
module nand_rb_tracker
  import nand_seq_pkg::*;
#(
  parameter int BLANK = BLANK_CYC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREG-1:0] rb_n,
  input  logic            blank_start,
  input  logic            blank_region,
  output logic [NREG-1:0] stall
);
  localparam int CW = $clog2(BLANK + 1);

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [1:0]    sync_q;
    logic [CW-1:0] blank_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q  <= 2'b11;
        blank_q <= '0;
      end else begin
        sync_q <= {sync_q[0], rb_n[r]};
        if (blank_start && (blank_region == 1'(r)))
          blank_q <= CW'(BLANK);
        else if (blank_q != '0)
          blank_q <= blank_q - 1'b1;
      end
    end

    assign stall[r] = !sync_q[1] || (blank_q != '0);
  end
endmodule

// File: rtl/nand_strobe_timer.sv
module nand_strobe_timer #(
  parameter int LO = 3,
  parameter int HI = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_lo,
  input  logic start_hi,
  output logic last
);
  localparam int MAXW = (LO > HI) ? LO : HI;
  localparam int CW   = $clog2(MAXW + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (start_lo)     cnt_q <= CW'(LO - 1);
    else if (start_hi)     cnt_q <= CW'(HI - 1);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq
  import nand_seq_pkg::*;
#(
  parameter int STROBE_LO = 3,
  parameter int STROBE_HI = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_kind,
  input  logic            req_region,
  input  logic            req_guard,
  input  logic [7:0]      req_byte,
  output logic            rd_valid,
  output logic [7:0]      rd_byte,
  output logic            err,
  input  logic            wp_n,
  output logic [NREG-1:0] ce_n,
  output logic            cle,
  output logic            ale,
  output logic            we_n,
  output logic            re_n,
  output logic [7:0]      io_out,
  output logic            io_oe,
  input  logic [7:0]      io_in,
  input  logic [NREG-1:0] rb_n
);
  phase_e          phase_q;
  kind_e           kind_q;
  logic            region_q;
  logic [7:0]      byte_q;
  logic            last;
  logic [NREG-1:0] stall;

  // named events for the checker
  logic accept, wp_refuse, launch, cyc_active, stall_sel, strobe_done, blank_start;

  assign stall_sel   = stall[req_region];
  assign req_ready   = (phase_q == P_IDLE) && !stall_sel;
  assign accept      = req_valid && req_ready;
  assign wp_refuse   = accept && is_refused(kind_e'(req_kind), req_guard, wp_n);
  assign launch      = accept && !wp_refuse;
  assign cyc_active  = (phase_q != P_IDLE);
  assign strobe_done = (phase_q == P_LOW) && last;
  assign blank_start = (phase_q == P_HIGH) && last && (kind_q == K_CMD);

  nand_strobe_timer #(.LO(STROBE_LO), .HI(STROBE_HI)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_lo (phase_q == P_SETUP),
    .start_hi (strobe_done),
    .last     (last)
  );

  nand_rb_tracker #(.BLANK(BLANK_CYC)) u_rb (
    .clk          (clk),
    .rst_n        (rst_n),
    .rb_n         (rb_n),
    .blank_start  (blank_start),
    .blank_region (region_q),
    .stall        (stall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= P_IDLE;
      kind_q   <= K_CMD;
      region_q <= 1'b0;
      byte_q   <= '0;
      rd_valid <= 1'b0;
      rd_byte  <= '0;
      err      <= 1'b0;
    end else begin
      err      <= wp_refuse;
      rd_valid <= strobe_done && (kind_q == K_RD);
      if (strobe_done && (kind_q == K_RD)) rd_byte <= io_in;
      unique case (phase_q)
        P_IDLE: if (launch) begin
          phase_q  <= P_SETUP;
          kind_q   <= kind_e'(req_kind);
          region_q <= req_region;
          byte_q   <= req_byte;
        end
        P_SETUP: phase_q <= P_LOW;
        P_LOW:   if (last) phase_q <= P_HIGH;
        P_HIGH:  if (last) phase_q <= P_IDLE;
        default: phase_q <= P_IDLE;
      endcase
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_ce
    assign ce_n[r] = !(cyc_active && (region_q == 1'(r)));
  end

  always_comb begin
    cle    = cyc_active && (kind_q == K_CMD);
    ale    = cyc_active && (kind_q == K_ADDR);
    we_n   = !((phase_q == P_LOW) && host_drives(kind_q));
    re_n   = !((phase_q == P_LOW) && (kind_q == K_RD));
    io_oe  = cyc_active && host_drives(kind_q);
    io_out = byte_q;
  end
endmodule

// File: rtl/nand_bus_seq_checker.sv
module nand_bus_seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic [1:0] ce_n,
  input logic       cle,
  input logic       ale,
  input logic       we_n,
  input logic       re_n,
  input logic       io_oe,
  input logic       rd_valid,
  input logic       err,
  input logic       cyc_active,
  input logic       wp_refuse,
  input logic       launch,
  input logic       stall_sel
);
  a_r12_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_active |-> !req_ready);
  a_r8_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ce_n));
  a_r4_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
  a_r4_latch_setup: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(we_n) || $fell(re_n)) |-> ($stable(cle) && $stable(ale)));
  a_r6_read_released: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> (!io_oe && we_n));
  a_r9_refuse_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    wp_refuse |=> (err && we_n && (ce_n == 2'b11)));
  a_r7_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(!re_n) && re_n));
  a_r10_no_launch_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !stall_sel);
endmodule

bind nand_bus_seq nand_bus_seq_checker chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .ce_n       (ce_n),
  .cle        (cle),
  .ale        (ale),
  .we_n       (we_n),
  .re_n       (re_n),
  .io_oe      (io_oe),
  .rd_valid   (rd_valid),
  .err        (err),
  .cyc_active (cyc_active),
  .wp_refuse  (wp_refuse),
  .launch     (launch),
  .stall_sel  (stall_sel)
);

// File: tb/nand_bus_seq_test.sv
`timescale 1ns/1ps
module nand_bus_seq_test;
  localparam int LO = 3;
  localparam int HI = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_kind = 2'd0;
  logic       req_region = 1'b0;
  logic       req_guard = 1'b0;
  logic [7:0] req_byte = 8'h00;
  logic       rd_valid;
  logic [7:0] rd_byte;
  logic       err;
  logic       wp_n = 1'b1;
  logic [1:0] ce_n;
  logic       cle, ale, we_n, re_n, io_oe;
  logic [7:0] io_out;
  logic [7:0] io_in;
  logic [1:0] rb_n = 2'b11;
  logic [7:0] flash_byte = 8'h00;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;
  assign io_in = re_n ? 8'h00 : flash_byte;

  nand_bus_seq #(.STROBE_LO(LO), .STROBE_HI(HI)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_region(req_region), .req_guard(req_guard),
    .req_byte(req_byte), .rd_valid(rd_valid), .rd_byte(rd_byte), .err(err),
    .wp_n(wp_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in), .rb_n(rb_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {kind, region, guard, wp_n, byte, flash}
  localparam int NV = 8;
  localparam logic [20:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b0, 1'b1, 8'h80, 8'h00},
    {2'd1, 1'b1, 1'b0, 1'b1, 8'h5A, 8'h00},
    {2'd2, 1'b0, 1'b0, 1'b1, 8'hC3, 8'h00},
    {2'd3, 1'b1, 1'b0, 1'b1, 8'h00, 8'hA5},
    {2'd0, 1'b1, 1'b1, 1'b1, 8'h10, 8'h00},
    {2'd0, 1'b0, 1'b1, 1'b0, 8'h60, 8'h00},
    {2'd3, 1'b0, 1'b0, 1'b0, 8'h00, 8'h3C},
    {2'd1, 1'b0, 1'b1, 1'b0, 8'h07, 8'h00}
  };

  task automatic run_req(input logic [1:0] k, input logic rg, input logic gd,
                         input logic wp, input logic [7:0] b, input logic [7:0] fb);
    int n_lo = 0, n_hi = 0, n_rdv = 0, n_err = 0, wait_n = 0;
    bit lat_ok = 1, bus_ok = 1, ce_ok = 1, setup_ok = 1, rdy_ok = 1, strb_ok = 1;
    bit refused;
    logic [7:0] got = 8'h00;
    logic [1:0] ce_exp;
    refused = (k == 2'd0) && gd && !wp;
    ce_exp = rg ? 2'b01 : 2'b10;
    @(negedge clk);
    req_kind = k; req_region = rg; req_guard = gd; req_byte = b;
    wp_n = wp; flash_byte = fb; req_valid = 1'b1;
    #1;
    while (!req_ready && wait_n < 50) begin @(negedge clk); wait_n++; end
    check(req_ready, "R10 request never accepted", 0, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < LO + HI + 2; i++) begin
      if (i > 0) @(negedge clk);
      if (err) n_err++;
      if (rd_valid) begin n_rdv++; got = rd_byte; end
      if (i == 0 && !refused)
        setup_ok = (cle == (k == 2'd0)) && (ale == (k == 2'd1)) && we_n && re_n;
      if (i <= LO + HI && !refused && req_ready) rdy_ok = 0;
      if (!we_n || !re_n) begin
        n_lo++;
        if (cle != (k == 2'd0) || ale != (k == 2'd1)) lat_ok = 0;
        if (io_oe != (k != 2'd3)) bus_ok = 0;
        if (k != 2'd3 && io_out != b) bus_ok = 0;
        if ((k == 2'd3) == re_n || (k == 2'd3) != we_n) strb_ok = 0;
      end else if (ce_n != 2'b11) begin
        n_hi++;
      end
      if (ce_n != 2'b11 && ce_n != ce_exp) ce_ok = 0;
    end
    if (refused) begin
      check(n_err == 1, "R9 err pulse count", n_err, 1);
      check(n_lo == 0 && n_hi == 0, "R9 no bus activity", n_lo + n_hi, 0);
    end else begin
      check(n_err == 0, "R9 no err on allowed request", n_err, 0);
      check(n_lo == LO, "R5 strobe low clocks", n_lo, LO);
      check(n_hi == HI + 1, "R5 enable-high-strobe clocks", n_hi, HI + 1);
      check(setup_ok, "R4 latch lines one clock early", cle, (k == 2'd0));
      check(lat_ok, (k == 2'd0) ? "R2 cle during command" : "R3 latch lines", {cle, ale}, k);
      check(bus_ok, "R6 bus direction and R2 byte", io_out, b);
      check(strb_ok, "R7 strobe choice", {we_n, re_n}, k);
      check(ce_ok, "R8 only selected enable", ce_n, ce_exp);
      check(rdy_ok, "R12 ready low while busy", 1, 0);
      if (k == 2'd3) begin
        check(n_rdv == 1, "R7 rd_valid pulse count", n_rdv, 1);
        check(got == fb, "R7 read byte", got, fb);
      end else begin
        check(n_rdv == 0, "R7 no rd_valid", n_rdv, 0);
      end
    end
    check(ce_n == 2'b11, "R8 enables released", ce_n, 3);
  endtask

  initial begin
    int wd = 0;
    while (wd < 100000) begin @(posedge clk); wd++; end
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=<%0d", wd, 100000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ce_n == 2'b11 && !cle && !ale && we_n && re_n && !io_oe && req_ready,
          "R1 reset state", {ce_n, cle, ale, we_n, re_n, io_oe, req_ready}, 8'b11001101);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      run_req(VEC[v][20:19], VEC[v][18], VEC[v][17], VEC[v][16], VEC[v][15:8], VEC[v][7:0]);
      repeat (6) @(negedge clk);
    end

    // R11 blanking after a command on region 0
    run_req(2'd0, 1'b0, 1'b0, 1'b1, 8'h70, 8'h00);
    req_region = 1'b0; #1;
    check(!req_ready, "R11 blanked right after command", req_ready, 0);
    req_region = 1'b1; #1;
    check(req_ready, "R11 other region not blanked", req_ready, 1);
    req_region = 1'b0;
    repeat (3) @(negedge clk);
    #1 check(!req_ready, "R11 still blanked at third clock", req_ready, 0);
    @(negedge clk);
    #1 check(req_ready, "R11 ready after four clocks", req_ready, 1);

    // R10 busy region holds requests, other region proceeds
    rb_n = 2'b01;
    repeat (3) @(negedge clk);
    req_region = 1'b1; #1;
    check(!req_ready, "R10 busy region not ready", req_ready, 0);
    req_region = 1'b0; #1;
    check(req_ready, "R10 idle region ready", req_ready, 1);
    req_kind = 2'd1; req_region = 1'b1; req_guard = 1'b0; req_valid = 1'b1;
    begin
      bit quiet = 1;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        if (ce_n != 2'b11 || req_ready) quiet = 0;
      end
      check(quiet, "R10 request held while busy", ce_n, 3);
    end
    req_valid = 1'b0;
    run_req(2'd2, 1'b0, 1'b0, 1'b1, 8'h9E, 8'h00);
    rb_n = 2'b11;
    run_req(2'd1, 1'b1, 1'b0, 1'b1, 8'h33, 8'h00);

    // R9 refused guarded command does not blank the region
    run_req(2'd0, 1'b1, 1'b1, 1'b0, 8'hD0, 8'h00);
    req_region = 1'b1; #1;
    check(req_ready, "R9 ready after refusal", req_ready, 1);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule